// File: doc/BRIEF.md
# Multi-Channel PPM Frequency Monitor

This block compares several input clocks against one local reference clock and expresses each clock's frequency error as a signed offset in steps of about 3.8 ppm. Each input arrives as an enable pulse, one pulse per input clock cycle, already synchronised to the reference domain. A free-running gate counter sets a fixed window of reference cycles. Each channel counts its pulses over that window. At the end of the window the channel subtracts the nominal count, saturates the difference and stores it as that channel's result.

One common acceptance limit applies to every channel. The limit is given in steps, and a setting above 16 steps (about ±61 ppm) is treated as 16. A channel's out-of-limit flag is recomputed only at the end of a window, so software sees stable values for a whole window. A channel-select input picks which stored result appears on the single readback output. The readback is registered, so it follows a new selection one clock later. Changing the selection never disturbs a measurement.

Top module: `ppm_freq_monitor`

## Requirements
- R1: Every WINDOW reference cycles after reset, each channel stores its offset: the number of clock-enable pulses sampled during that window minus NOMINAL, as a two's-complement value of RES_W bits.
- R2: The stored offset saturates symmetrically at ±(2^(RES_W-1)-1). With RES_W=8, a difference of +128 stores 127 and a difference of -128 stores -127.
- R3: At the end of a window, a channel's flag is set when the magnitude of its stored offset is strictly greater than the effective limit, and is cleared otherwise. An offset equal to the limit leaves the flag clear.
- R4: The effective limit is the limit input, unsigned, clamped to MAX_LIM (16 steps). A setting of 31 therefore behaves exactly like 16.
- R5: Stored offsets and flags change only at the last cycle of a window and hold their values between window ends.
- R6: The readback output shows the stored offset of channel chan_sel one clock after chan_sel is presented. A chan_sel value of N_CH or more reads zero.
- R7: While reset is low, and after it until the first window completes, every flag reads 0 and the readback reads 0.
- R8: Changing chan_sel at any time has no effect on the window timing or on the offsets being measured.
- R9: Each channel is measured and flagged independently, all against the same limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_in | input | N_CH | One enable pulse per input clock cycle, per channel |
| limit | input | LIM_W | Acceptance limit in steps, clamped to MAX_LIM |
| chan_sel | input | SEL_W | Channel whose offset is shown on the readback |
| offset_rd | output | RES_W | Signed stored offset of the selected channel (registered) |
| out_of_limit | output | N_CH | Per-channel out-of-limit flag |

## Verification
The bench builds the block with three channels, a 256-cycle window, a nominal count of 128, an 8-bit result and a 5-bit limit. With these values a whole measurement takes only a few hundred cycles. It also means that a channel enabled on every cycle, or on no cycle, reaches both saturation points. The bench can set exactly how many pulses fall inside each window, so it reaches offsets that sit one step either side of the limit, the clamp of an oversized limit, and an out-of-range select. Previous results are read back during the next window while the select value changes every cycle. These checks show that the stored results hold steady and that measurement continues undisturbed.

// File: rtl/pfm_pkg.sv
// Package pfm_pkg
// Shared helper functions for the ppm frequency monitor.
// Assumes every value passed in fits a 32-bit int.
package pfm_pkg;

    // Magnitude of a signed value, as an unsigned quantity.
    function automatic int unsigned mag_of(input int signed v);
        return (v < 0) ? $unsigned(-v) : $unsigned(v);
    endfunction

    // True when a signed offset lies strictly outside +/- bound.
    function automatic bit beyond(input int signed v, input int unsigned bound);
        return mag_of(v) > bound;
    endfunction

endpackage

// File: rtl/pfm_gate.sv
// Module pfm_gate
// Free-running gate counter. It produces a one-cycle marker on the last
// reference cycle of each measurement window of WINDOW cycles.
// Assumes WINDOW >= 2. The counter restarts from zero on reset.
module pfm_gate #(
    parameter int WINDOW = 524288
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int GW = $clog2(WINDOW);
    localparam logic [GW-1:0] LAST = GW'(WINDOW - 1);

    logic [GW-1:0] gate_cnt;

    // Count reference cycles and wrap at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                gate_cnt <= '0;
        else if (gate_cnt == LAST) gate_cnt <= '0;
        else                       gate_cnt <= gate_cnt + 1'b1;
    end

    // Mark the last cycle of the window.
    assign win_end = (gate_cnt == LAST);

    assert_gate_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cnt == LAST) |=> (gate_cnt == '0));
    assert_gate_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cnt != LAST) |=> (gate_cnt == $past(gate_cnt) + 1'b1));

endmodule

// File: rtl/pfm_channel.sv
// Module pfm_channel
// One measurement channel. It counts enable pulses over the window and, on
// the window's last cycle, stores the saturated offset from NOMINAL and the
// out-of-limit flag.
// Assumes NOMINAL <= WINDOW < 2**CNT_W and an already clamped limit.
module pfm_channel
    import pfm_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int NOMINAL = 262144,
    parameter int RES_W   = 8,
    parameter int LIM_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_end,
    input  logic                    tick,
    input  logic [LIM_W-1:0]        lim_eff,
    output logic signed [RES_W-1:0] result,
    output logic                    over
);
    localparam int DW   = CNT_W + 2;
    localparam int SMAX = 2 ** (RES_W - 1) - 1;

    logic [CNT_W-1:0]        acc;
    logic [CNT_W-1:0]        total;
    logic signed [DW-1:0]    diff;
    logic signed [RES_W-1:0] res_next;
    logic                    over_next;

    // Accumulate pulses; the window's last cycle restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (win_end) acc <= '0;
        else if (tick)    acc <= acc + 1'b1;
    end

    // Offset of the completed count from nominal, saturated, then compared.
    always_comb begin
        total = acc + CNT_W'(tick);
        diff  = $signed({2'b00, total}) - $signed(DW'(NOMINAL));
        if (int'(diff) > SMAX)       res_next = RES_W'(SMAX);
        else if (int'(diff) < -SMAX) res_next = RES_W'(-SMAX);
        else                         res_next = RES_W'(diff);
        over_next = beyond(int'(res_next), 32'(lim_eff));
    end

    // Store result and flag only at the window's end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            over   <= 1'b0;
        end else if (win_end) begin
            result <= res_next;
            over   <= over_next;
        end
    end

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(result));
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(over));
    assert_sat_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(result) <= SMAX) && (int'(result) >= -SMAX));
    assert_flag_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (over == beyond(int'(result), 32'($past(lim_eff)))));

endmodule

// File: rtl/pfm_readmux.sv
// Module pfm_readmux
// Registered readback selector. It shows the chosen channel's stored offset
// one cycle after the selection, and zero for an unused select code.
// Assumes the results arrive packed, with channel i in slice i.
module pfm_readmux #(
    parameter int N_CH  = 4,
    parameter int RES_W = 8,
    parameter int SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH*RES_W-1:0]   res_flat,
    input  logic [SEL_W-1:0]        sel,
    output logic signed [RES_W-1:0] rd
);
    logic [RES_W-1:0] picked;

    // Pick the selected slice; unmatched codes give zero.
    always_comb begin
        picked = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (sel == SEL_W'(i)) picked = res_flat[i*RES_W +: RES_W];
        end
    end

    // Register the readback.
    always_ff @(posedge clk) begin
        if (!rst_n) rd <= '0;
        else        rd <= $signed(picked);
    end

    assert_sel_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) >= N_CH) |=> (rd == '0));

endmodule

// File: rtl/ppm_freq_monitor.sv
// Module ppm_freq_monitor
// Multi-channel frequency-offset monitor. A shared gate window and one
// counter per channel give signed ppm-step offsets and out-of-limit flags,
// with a multiplexed readback.
// Assumes the enables are already synchronous to clk and MAX_LIM < 2**LIM_W.
module ppm_freq_monitor #(
    parameter int N_CH    = 4,
    parameter int WINDOW  = 524288,
    parameter int NOMINAL = 262144,
    parameter int RES_W   = 8,
    parameter int LIM_W   = 5,
    parameter int MAX_LIM = 16,
    localparam int SEL_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         clk_en_in,
    input  logic [LIM_W-1:0]        limit,
    input  logic [SEL_W-1:0]        chan_sel,
    output logic signed [RES_W-1:0] offset_rd,
    output logic [N_CH-1:0]         out_of_limit
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [LIM_W-1:0] LIM_TOP = LIM_W'(MAX_LIM);

    logic                  win_end;
    logic [LIM_W-1:0]      lim_eff;
    logic [N_CH*RES_W-1:0] res_flat;

    // Clamp the programmed limit to the largest allowed step count.
    always_comb lim_eff = (limit > LIM_TOP) ? LIM_TOP : limit;

    pfm_gate #(.WINDOW(WINDOW)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic signed [RES_W-1:0] ch_res;
        pfm_channel #(
            .CNT_W   (CNT_W),
            .NOMINAL (NOMINAL),
            .RES_W   (RES_W),
            .LIM_W   (LIM_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .win_end (win_end),
            .tick    (clk_en_in[ch]),
            .lim_eff (lim_eff),
            .result  (ch_res),
            .over    (out_of_limit[ch])
        );
        assign res_flat[ch*RES_W +: RES_W] = ch_res;
    end

    pfm_readmux #(.N_CH(N_CH), .RES_W(RES_W), .SEL_W(SEL_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_flat (res_flat),
        .sel      (chan_sel),
        .rd       (offset_rd)
    );

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> ((out_of_limit == '0) && (offset_rd == '0)));
    assert_limit_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lim_eff <= LIM_TOP);

endmodule

// File: tb/ppm_freq_monitor_test.sv
// Directed bench: one task per scenario, 100 MHz clock.
module ppm_freq_monitor_test;
    localparam int N_CH = 3, WINDOW = 256, NOMINAL = 128, RES_W = 8;
    localparam int LIM_W = 5, MAX_LIM = 16, SMAX = 127;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_CH-1:0] en = '0;
    logic [LIM_W-1:0] lim = '0;
    logic [1:0] sel = '0;
    logic signed [RES_W-1:0] rd;
    logic [N_CH-1:0] flags;

    int checks = 0, errors = 0;
    int exp_prev [N_CH] = '{0, 0, 0};
    logic [N_CH-1:0] flag_prev = '0;

    always #5 clk = ~clk;

    ppm_freq_monitor #(
        .N_CH(N_CH), .WINDOW(WINDOW), .NOMINAL(NOMINAL),
        .RES_W(RES_W), .LIM_W(LIM_W), .MAX_LIM(MAX_LIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .clk_en_in(en), .limit(lim),
        .chan_sel(sel), .offset_rd(rd), .out_of_limit(flags)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full window with k pulses per channel; checks the previous
    // window's readback and the flag hold, then the new flags.
    task automatic run_window(input int k0, input int k1, input int k2, input int lv);
        int kk [N_CH] = '{k0, k1, k2};
        int eff;
        int off;
        logic [N_CH-1:0] f_exp;
        for (int c = 0; c < WINDOW; c++) begin
            for (int i = 0; i < N_CH; i++) en[i] = (c < kk[i]);
            lim = LIM_W'(lv);
            sel = (c < 4) ? 2'(c) : 2'(c % 3);
            @(negedge clk);
            if (c < N_CH) check("R1/R2/R6/R8 readback", int'(rd), exp_prev[c]);
            if (c == 3)   check("R6 unused select", int'(rd), 0);
            if (c == WINDOW / 2) check("R5 flags hold", int'(flags), int'(flag_prev));
        end
        eff = (lv > MAX_LIM) ? MAX_LIM : lv;
        for (int i = 0; i < N_CH; i++) begin
            off = kk[i] - NOMINAL;
            if (off > SMAX)  off = SMAX;
            if (off < -SMAX) off = -SMAX;
            exp_prev[i] = off;
            f_exp[i] = ((off < 0) ? -off : off) > eff;
        end
        check("R3/R4/R9 flags", int'(flags), int'(f_exp));
        flag_prev = f_exp;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R7 flags in reset", int'(flags), 0);
        check("R7 readback in reset", int'(rd), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_nominal();      run_window(128, 128, 128, 4);   endtask
    task automatic t_mixed();        run_window(144, 111, 133, 16);  endtask
    task automatic t_limit_clamp();  run_window(145, 144, 112, 31);  endtask
    task automatic t_zero_limit();   run_window(129, 128, 127, 0);   endtask
    task automatic t_saturate();     run_window(256, 0, 128, 20);    endtask
    task automatic t_final();        run_window(128, 128, 128, 0);   endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_nominal();
        t_mixed();
        t_limit_clamp();
        t_zero_limit();
        t_saturate();
        t_final();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule